// File: doc/BRIEF.md
# Multi-Width Sequential Unsigned Divider

This block divides an unsigned dividend of twice the divisor's width by that divisor. One datapath serves three operand sizes: 16 by 8, 32 by 16 and 64 by 32 bits. It produces a quotient and a remainder of the divisor's width. When the divisor is zero, or when the true quotient cannot be held in the divisor width, the block raises a divide-error indication and produces no result.

A request starts with a one-cycle `start` pulse that carries the size code and the operands. The block first checks whether the request can succeed. It then spends a fixed number of setup cycles, and after that retires one quotient bit per clock using restoring shift-and-subtract. Completion is marked by a single-cycle `done` pulse. Quotient, remainder and the error flag then hold their values until the next accepted request.

Top module: `udiv_multi`

## Requirements
- R1: `size_sel` picks the operand size. Code 0 divides `dividend[15:0]` by `divisor[7:0]`, code 1 divides `dividend[31:0]` by `divisor[15:0]`, and codes 2 and 3 both divide `dividend[63:0]` by `divisor[31:0]`. Input bits above the active width have no effect on the result.
- R2: For a successful request, `quotient` is the dividend divided by the divisor with the fraction dropped, and `remainder` is the dividend minus quotient times divisor. The remainder is always strictly below the divisor.
- R3: A zero divisor, or a true quotient of 2^N or more (N being the active divisor width), completes with `div_err` set. In that case `quotient` and `remainder` keep the values they had before the request.
- R4: A successful request raises `done` 9+N clock edges after the edge that accepts `start`: 17, 25 and 41 edges for the three sizes.
- R5: A failing request raises `done` together with `div_err` on the edge right after the accepting edge.
- R6: `done` lasts exactly one cycle. `busy` is high from the accepting edge up to the edge that raises `done`, and it is low while `done` is high.
- R7: A `start` pulse that arrives while `busy` is high is ignored. It does not change the running request's result and does not produce an extra `done`.
- R8: `quotient`, `remainder` and `div_err` only change on the edge that raises `done`, with one exception: an accepted `start` clears `div_err`.
- R9: For the 8-bit and 16-bit sizes, the bits of `quotient` and `remainder` above the active width are zero.
- R10: `rst_n` low resets the block at once. After release, `busy`, `done`, `div_err`, `quotient` and `remainder` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| start | input | 1 | One-cycle request pulse, sampled only while idle |
| size_sel | input | 2 | Operand size code (0: 16/8, 1: 32/16, 2 or 3: 64/32) |
| dividend | input | 64 | Double-width dividend, low-aligned |
| divisor | input | 32 | Divisor, low-aligned |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Quotient of the last successful request, zero-extended |
| remainder | output | 32 | Remainder of the last successful request, zero-extended |
| div_err | output | 1 | Last completed request was a divide error |

## Verification
Each size is driven with hand-picked operands. One request has its quotient at the top of the range, which separates a correct fit test from an off-by-one compare against the high half. The neighbouring request has a quotient one above the limit, and another has a zero divisor; both must take the short error path and leave the previous result intact. Garbage placed above the active width of both operands shows whether the size masking is real. A batch of random operands, with the divisor's top active bit forced, checks the step logic against a reference quotient and remainder; the completion time of every request is compared with 9+N. One long request receives a second `start` partway through, which shows whether the controller is re-entered while busy.

// File: rtl/udiv_pkg.sv
package udiv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SETUP,
    ST_ITER,
    ST_FIN
  } udiv_state_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD2 = 2'd3
  } udiv_size_e;

endpackage

// File: rtl/udiv_rst_sync.sv
module udiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/udiv_align.sv
module udiv_align
  import udiv_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input  logic [1:0]     size_sel,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic [W-1:0]   hi_o,
  output logic [W-1:0]   lo_o,
  output logic [W-1:0]   dv_o,
  output logic [CW-1:0]  nbits_o
);

  localparam int LANES = 3;

  logic [W-1:0]  lane_hi [LANES];
  logic [W-1:0]  lane_lo [LANES];
  logic [W-1:0]  lane_dv [LANES];
  logic [CW-1:0] lane_n  [LANES];

  // lane k works on a divisor width of W >> (2-k)
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int NW = W >> (LANES - 1 - k);
    assign lane_hi[k] = W'(dividend[2*NW-1:NW]);
    assign lane_lo[k] = W'(dividend[NW-1:0]) << (W - NW);
    assign lane_dv[k] = W'(divisor[NW-1:0]);
    assign lane_n[k]  = CW'(NW);
  end

  always_comb begin
    unique case (udiv_size_e'(size_sel))
      SZ_BYTE: begin
        hi_o = lane_hi[0]; lo_o = lane_lo[0]; dv_o = lane_dv[0]; nbits_o = lane_n[0];
      end
      SZ_HALF: begin
        hi_o = lane_hi[1]; lo_o = lane_lo[1]; dv_o = lane_dv[1]; nbits_o = lane_n[1];
      end
      default: begin
        hi_o = lane_hi[2]; lo_o = lane_lo[2]; dv_o = lane_dv[2]; nbits_o = lane_n[2];
      end
    endcase
  end

endmodule

// File: rtl/udiv_step.sv
module udiv_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] prem,
  input  logic         bit_in,
  input  logic [W-1:0] dv,
  output logic [W-1:0] prem_nx,
  output logic         qbit
);

  logic [W:0] shifted;
  logic [W:0] diff;

  always_comb begin
    shifted = {prem, bit_in};
    diff    = shifted - {1'b0, dv};
    qbit    = (shifted >= {1'b0, dv});
    prem_nx = qbit ? diff[W-1:0] : shifted[W-1:0];
  end

endmodule

// File: rtl/udiv_core.sv
module udiv_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  input  logic [W-1:0] dv_in,
  output logic         err_pre,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] dv_o
);

  logic [W-1:0] pr_q, lo_q, qt_q, dv_q;
  logic [W-1:0] pr_d, lo_d, qt_d, dv_d;
  logic [W-1:0] pr_nx;
  logic         qbit;
  logic         en;

  udiv_step #(.W(W)) u_step (
    .prem    (pr_q),
    .bit_in  (lo_q[W-1]),
    .dv      (dv_q),
    .prem_nx (pr_nx),
    .qbit    (qbit)
  );

  always_comb begin
    en   = load | step;
    pr_d = pr_q;
    lo_d = lo_q;
    qt_d = qt_q;
    dv_d = dv_q;
    if (load) begin
      pr_d = hi_in;
      lo_d = lo_in;
      qt_d = '0;
      dv_d = dv_in;
    end else if (step) begin
      pr_d = pr_nx;
      lo_d = {lo_q[W-2:0], 1'b0};
      qt_d = {qt_q[W-2:0], qbit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_q <= '0;
      lo_q <= '0;
      qt_q <= '0;
      dv_q <= '0;
    end else if (en) begin
      pr_q <= pr_d;
      lo_q <= lo_d;
      qt_q <= qt_d;
      dv_q <= dv_d;
    end
  end

  // the quotient fits only if the high half is below the divisor
  assign err_pre = (dv_q == '0) || (pr_q >= dv_q);
  assign quo_o   = qt_q;
  assign rem_o   = pr_q;
  assign dv_o    = dv_q;

  // R2
  prem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (pr_q < dv_q));

endmodule

// File: rtl/udiv_ctrl.sv
module udiv_ctrl
  import udiv_pkg::*;
#(
  parameter int CW        = 6,
  parameter int SETUP_CYC = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] nbits_in,
  input  logic          err_pre,
  output logic          load,
  output logic          step,
  output logic          fin_ok,
  output logic          fin_err,
  output logic          busy
);

  udiv_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] nb_q, nb_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    nb_d  = nb_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d = ST_CHECK;
          nb_d = nbits_in;
        end
      end
      ST_CHECK: begin
        if (err_pre) begin
          st_d = ST_IDLE;
        end else begin
          st_d  = ST_SETUP;
          cnt_d = CW'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (cnt_q == '0) begin
          st_d  = ST_ITER;
          cnt_d = nb_q - CW'(1);
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_ITER: begin
        if (cnt_q == '0) begin
          st_d = ST_FIN;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      nb_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      nb_q  <= nb_d;
    end
  end

  assign load    = (st_q == ST_IDLE) && start;
  assign step    = (st_q == ST_ITER);
  assign fin_ok  = (st_q == ST_FIN);
  assign fin_err = (st_q == ST_CHECK) && err_pre;
  assign busy    = (st_q != ST_IDLE);

  // R7
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && start) |=> (st_q != ST_CHECK));

  // R4
  iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ITER) |-> (cnt_q < nb_q));

endmodule

// File: rtl/udiv_multi.sv
module udiv_multi #(
  parameter int W        = 32,
  parameter int OVERHEAD = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     size_sel,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder,
  output logic           div_err
);

  localparam int CW        = $clog2(W + 1);
  localparam int SETUP_CYC = OVERHEAD - 2;

  logic          rst_sn;
  logic [W-1:0]  al_hi, al_lo, al_dv;
  logic [CW-1:0] al_n;
  logic          load, step, fin_ok, fin_err;
  logic          err_pre;
  logic [W-1:0]  core_quo, core_rem, core_dv;

  logic [W-1:0]  quo_q, quo_d, rem_q, rem_d;
  logic          err_q, err_d, done_q, done_d;

  udiv_rst_sync #(.STAGES(2)) u_rsync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sn)
  );

  udiv_align #(.W(W), .CW(CW)) u_align (
    .size_sel (size_sel),
    .dividend (dividend),
    .divisor  (divisor),
    .hi_o     (al_hi),
    .lo_o     (al_lo),
    .dv_o     (al_dv),
    .nbits_o  (al_n)
  );

  udiv_ctrl #(.CW(CW), .SETUP_CYC(SETUP_CYC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sn),
    .start    (start),
    .nbits_in (al_n),
    .err_pre  (err_pre),
    .load     (load),
    .step     (step),
    .fin_ok   (fin_ok),
    .fin_err  (fin_err),
    .busy     (busy)
  );

  udiv_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_sn),
    .load    (load),
    .step    (step),
    .hi_in   (al_hi),
    .lo_in   (al_lo),
    .dv_in   (al_dv),
    .err_pre (err_pre),
    .quo_o   (core_quo),
    .rem_o   (core_rem),
    .dv_o    (core_dv)
  );

  always_comb begin
    quo_d  = quo_q;
    rem_d  = rem_q;
    err_d  = err_q;
    done_d = 1'b0;
    if (fin_ok) begin
      quo_d  = core_quo;
      rem_d  = core_rem;
      done_d = 1'b1;
    end else if (fin_err) begin
      err_d  = 1'b1;
      done_d = 1'b1;
    end else if (load) begin
      err_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      quo_q  <= '0;
      rem_q  <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      err_q  <= err_d;
      done_q <= done_d;
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;
  assign div_err   = err_q;
  assign done      = done_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> !busy);

  // R3
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(div_err) |-> done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !done |-> ($stable(quotient) && $stable(remainder)));

  // R2
  rem_below_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && !div_err) |-> (remainder < core_dv));

endmodule

// File: tb/sim_udiv_multi.sv
module sim_udiv_multi;

  localparam int W = 32;

  typedef struct packed {
    logic        err;
    logic [31:0] q;
    logic [31:0] r;
    int          lat;
    int          t0;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [1:0]    size_sel;
  logic [2*W-1:0] dividend;
  logic [W-1:0]  divisor;
  logic          busy, done, div_err;
  logic [W-1:0]  quotient, remainder;

  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;
  exp_t sbq[$];
  string tagq[$];
  logic [31:0] last_q = '0;
  logic [31:0] last_r = '0;
  logic        last_err = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  udiv_multi #(.W(W)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .size_sel  (size_sel),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .div_err   (div_err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // reference model taken from R1-style size codes, R2 and R3
  function automatic exp_t model(input logic [1:0] sz, input logic [63:0] dvd,
                                 input logic [31:0] dvs);
    exp_t e;
    int n;
    logic [63:0] dm, vm, d, v, q64;
    n  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    dm = (n == 32) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (2*n)) - 64'd1);
    vm = (64'd1 << n) - 64'd1;
    d  = dvd & dm;
    v  = {32'd0, dvs} & vm;
    e  = '0;
    if (v == 64'd0) begin
      e.err = 1'b1;
    end else begin
      q64 = d / v;
      if (q64 > vm) begin
        e.err = 1'b1;
      end else begin
        e.q = q64[31:0];
        q64 = d % v;
        e.r = q64[31:0];
      end
    end
    e.lat = e.err ? 1 : 9 + n;
    return e;
  endfunction

  task automatic issue(input logic [1:0] sz, input logic [63:0] dvd,
                       input logic [31:0] dvs, input string tag, input bit poke);
    exp_t e;
    e = model(sz, dvd, dvs);
    @(negedge clk);
    // R8: nothing moved since the previous completion
    chk(quotient == last_q, "R8", "quotient held", {32'd0, quotient}, {32'd0, last_q});
    chk(remainder == last_r && div_err == last_err, "R8", "remainder/err held",
        {31'd0, div_err, remainder}, {31'd0, last_err, last_r});
    size_sel = sz;
    dividend = dvd;
    divisor  = dvs;
    start    = 1'b1;
    @(posedge clk);
    #1;
    e.t0 = cyc;
    sbq.push_back(e);
    tagq.push_back(tag);
    start = 1'b0;
    chk(busy == 1'b1, "R6", "busy after accept", {63'd0, busy}, 64'd1);
    if (poke) begin
      // R7: second request while busy
      repeat (3) @(negedge clk);
      start    = 1'b1;
      size_sel = 2'd0;
      dividend = ~dvd;
      divisor  = dvs ^ 32'h5;
      @(negedge clk);
      start = 1'b0;
    end
    do @(negedge clk); while (busy);
  endtask

  // monitor: pops the scoreboard on every completion
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R7", "unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        string t;
        e = sbq.pop_front();
        t = tagq.pop_front();
        chk((cyc - e.t0) == e.lat, e.err ? "R5" : "R4", "latency",
            64'(cyc - e.t0), 64'(e.lat));
        chk(div_err == e.err, t, "div_err", {63'd0, div_err}, {63'd0, e.err});
        if (e.err) begin
          chk(quotient == last_q && remainder == last_r, "R3", "result kept on error",
              {remainder, quotient}, {last_r, last_q});
        end else begin
          chk(quotient == e.q, t, "quotient", {32'd0, quotient}, {32'd0, e.q});
          chk(remainder == e.r, t, "remainder", {32'd0, remainder}, {32'd0, e.r});
        end
        last_q   = quotient;
        last_r   = remainder;
        last_err = div_err;
      end
    end
  end

  initial begin
    rst_n    = 1'b0;
    start    = 1'b0;
    size_sel = 2'd0;
    dividend = '0;
    divisor  = '0;
    repeat (3) @(negedge clk);
    // R10: in reset
    chk(!busy && !done && !div_err, "R10", "flags in reset",
        {61'd0, busy, done, div_err}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: after release
    chk(quotient == '0 && remainder == '0, "R10", "outputs after reset",
        {remainder, quotient}, 64'd0);
    chk(!busy && !done && !div_err, "R10", "flags after reset",
        {61'd0, busy, done, div_err}, 64'd0);

    // 16/8 size
    issue(2'd0, 64'd1000, 32'd7, "R2", 1'b0);
    issue(2'd0, 64'h0000_0000_0000_FEFF, 32'h0000_00FF, "R2", 1'b0);
    issue(2'd0, 64'h0000_0000_0000_0100, 32'd1, "R3", 1'b0);
    issue(2'd0, 64'd55, 32'd0, "R3", 1'b0);
    issue(2'd0, 64'hDEAD_BEEF_CAFE_03E8, 32'hABCD_EF07, "R1", 1'b0);
    chk(quotient[31:8] == '0 && remainder[31:8] == '0, "R9", "upper bits zero 8-bit",
        {remainder, quotient}, {32'd6, 32'd142});

    // 32/16 size
    issue(2'd1, 64'h0000_0000_1234_5678, 32'h0000_1234, "R3", 1'b0);
    issue(2'd1, 64'h0000_0000_0001_0000, 32'd2, "R2", 1'b0);
    issue(2'd1, 64'hFFFF_0000_0012_3457, 32'hFFFF_0100, "R1", 1'b0);
    chk(quotient[31:16] == '0 && remainder[31:16] == '0, "R9", "upper bits zero 16-bit",
        {remainder, quotient}, 64'd0);

    // 64/32 size
    issue(2'd2, 64'hFFFF_FFFE_0000_0001, 32'hFFFF_FFFF, "R2", 1'b0);
    issue(2'd2, 64'h0000_0000_89AB_CDEF, 32'd1, "R2", 1'b0);
    issue(2'd2, 64'h0000_0005_0000_0000, 32'd5, "R3", 1'b0);
    issue(2'd3, 64'h0000_0003_0000_0000, 32'd4, "R1", 1'b0);

    // start while busy
    issue(2'd2, 64'h0000_1234_5678_9ABC, 32'h0001_0003, "R7", 1'b1);

    // random operands, quotient forced to fit
    for (int i = 0; i < 30; i++) begin
      logic [1:0]  sz;
      int          n;
      logic [63:0] d;
      logic [31:0] v;
      sz = 2'(i % 3);
      n  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
      d  = {$urandom, $urandom} >> (64 - 2*n + 1);
      v  = $urandom | (32'd1 << (n - 1));
      issue(sz, d, v, "R2", 1'b0);
    end
    issue(2'd1, {$urandom, $urandom}, 32'd0, "R3", 1'b0);

    repeat (5) @(negedge clk);
    chk(sbq.size() == 0, "R7", "scoreboard drained", 64'(sbq.size()), 64'd0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule